// File: doc/BRIEF.md
# Start-up Sequencer with Deglitched Flags and Soft-Start Ramp

This block sits between already-digitized comparator flags and the reference input of a regulator's error path. It takes three raw flags: the supply is above its threshold, the enable pin is above its threshold, and the die is over temperature. It also takes a cool-down flag that reports when the die has fallen back below the release point. From these flags it produces a reference code and a run signal that gates the power stage.

The supply flag passes through a hold-time filter on both of its edges. The enable flag is filtered only when it falls, so a rising enable is taken at once provided the supply is good. When both flags are good and no thermal fault is pending, the sequencer enters a ramp state. In that state the reference code climbs by one step at a fixed prescaled interval, from zero to full scale. Reaching full scale moves the sequencer to steady running. Any fault drops the run signal and zeroes the code.

A thermal trip stays latched until the cool-down flag is seen. The next start then goes through the whole ramp again. A fault that persists therefore makes the block cycle through start, run and shutdown indefinitely, with no lockout.

Top module: `softstart_seq`

## Requirements
- R1: While reset is high and on the first cycle after it, runEn, rampDone and refCode are all 0.
- R2: The filtered supply flag changes state only after supplyOk has held the new value for HOLD_CYCLES consecutive clock edges, and any bounce restarts that count. runEn rises HOLD_CYCLES+1 edges after supplyOk rises, provided enableHi is already accepted.
- R3: A supply dropout shorter than HOLD_CYCLES edges leaves runEn high. A dropout held for HOLD_CYCLES edges drops runEn and clears refCode to 0 at edge HOLD_CYCLES+1.
- R4: Start-up requires both the filtered supply and the filtered enable. A rising enableHi is accepted at the next edge without filtering, and runEn rises one edge after that.
- R5: A low pulse on enableHi shorter than HOLD_CYCLES edges is ignored. A low level held for HOLD_CYCLES edges drops runEn and clears refCode at edge HOLD_CYCLES+1.
- R6: In the ramp state, refCode starts at 0 on the edge runEn rises. It then increases by exactly one every STEP_DIV edges and never skips a value.
- R7: refCode saturates at full scale, which is all ones across CODE_W bits. rampDone rises on the edge after refCode reaches full scale, and refCode then holds at full scale while running.
- R8: overTemp sampled high at an edge drops runEn and rampDone and sets refCode to 0 at that same edge.
- R9: A thermal trip is latched until coolDown is sampled high with overTemp low. If overTemp and coolDown are high together, the trip wins. The edge after the latch clears, runEn rises and the ramp restarts from 0.
- R10: Repeated trip and cool-down cycles each restart through the full ramp to rampDone, with no lockout.
- R11: Shutdown takes priority over ramp completion. If overTemp is sampled on the edge where the sequencer would enter running, rampDone stays 0 and refCode becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supplyOk | input | 1 | Raw supply-above-threshold flag |
| enableHi | input | 1 | Raw enable-above-threshold flag |
| overTemp | input | 1 | Raw over-temperature flag |
| coolDown | input | 1 | Raw flag: temperature below release point |
| refCode | output | CODE_W | Reference ramp code |
| runEn | output | 1 | Power stage run gate (ramp or running) |
| rampDone | output | 1 | High while in steady running |

## Verification
Two pairs of events can land on the same clock edge. In the first, the ramp reaches full scale just as a thermal trip arrives. The bench brings the code to full scale and then raises overTemp exactly for the edge on which the sequencer would otherwise enter running. It then requires rampDone to stay low and the code to read zero. In the second, the trip and the cool-down release arrive together. The bench drives overTemp and coolDown high on the same cycle and requires runEn to stay low afterwards, until a later cool-down alone restarts the ramp.

// File: rtl/ssq_pkg.sv
package ssq_pkg;
  typedef enum logic [1:0] {
    SEQ_OFF  = 2'd0,
    SEQ_RAMP = 2'd1,
    SEQ_RUN  = 2'd2
  } seqState_e;

  // strobes from control to ramp datapath
  typedef struct packed {
    logic clear;
    logic step;
  } rampCmd_t;
endpackage

// File: rtl/ssq_deglitch.sv
module ssq_deglitch #(
  parameter int HOLD_CYCLES = 250,
  parameter bit FILTER_RISE = 1'b1,
  parameter bit FILTER_FALL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CNT_W = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYCLES - 1);

  logic [CNT_W-1:0] holdCnt;
  logic edgeFiltered;

  assign edgeFiltered = rawIn ? FILTER_RISE : FILTER_FALL;

  always_ff @(posedge clk) begin
    if (rst) begin
      cleanOut <= 1'b0;
      holdCnt  <= '0;
    end else if (rawIn == cleanOut) begin
      holdCnt <= '0;
    end else if (!edgeFiltered || holdCnt == HOLD_LAST) begin
      cleanOut <= rawIn;
      holdCnt  <= '0;
    end else begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // R2
  clean_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cleanOut) |-> cleanOut == $past(rawIn));

  // R3
  quiet_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rawIn == cleanOut) |=> $stable(cleanOut));
endmodule

// File: rtl/ssq_ctrl.sv
module ssq_ctrl
  import ssq_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      supGood,
  input  logic      enGood,
  input  logic      overTemp,
  input  logic      coolDown,
  input  logic      rampFull,
  output seqState_e state,
  output rampCmd_t  cmd
);
  logic hotLatch;
  logic stopNow;
  logic startOk;
  seqState_e stateNext;

  assign stopNow = !supGood || !enGood || overTemp || hotLatch;
  assign startOk = supGood && enGood && !overTemp && !hotLatch;

  always_comb begin
    stateNext = state;
    unique case (state)
      SEQ_OFF:  if (startOk) stateNext = SEQ_RAMP;
      SEQ_RAMP: if (stopNow) stateNext = SEQ_OFF;
                else if (rampFull) stateNext = SEQ_RUN;
      SEQ_RUN:  if (stopNow) stateNext = SEQ_OFF;
      default:  stateNext = SEQ_OFF;
    endcase
  end

  always_comb begin
    cmd.clear = (state == SEQ_OFF) || stopNow;
    cmd.step  = (state == SEQ_RAMP) && !stopNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SEQ_OFF;
      hotLatch <= 1'b0;
    end else begin
      state <= stateNext;
      if (overTemp)      hotLatch <= 1'b1;
      else if (coolDown) hotLatch <= 1'b0;
    end
  end

  // R8
  temp_stop_chk: assert property (@(posedge clk) disable iff (rst)
    overTemp |=> state == SEQ_OFF);

  // R9
  hot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hotLatch |-> state == SEQ_OFF);

  // R4
  start_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_OFF && !(supGood && enGood)) |=> state == SEQ_OFF);

  // R11
  full_vs_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (state == SEQ_RAMP && rampFull && overTemp) |=> state == SEQ_OFF);
endmodule

// File: rtl/ssq_ramp.sv
module ssq_ramp
  import ssq_pkg::*;
#(
  parameter int CODE_W   = 10,
  parameter int STEP_DIV = 327
) (
  input  logic              clk,
  input  logic              rst,
  input  rampCmd_t          cmd,
  output logic [CODE_W-1:0] code,
  output logic              atFull
);
  localparam int PRE_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_DIV - 1);
  localparam logic [CODE_W-1:0] FULL_CODE = '1;
  localparam logic [CODE_W-1:0] CODE_ONE  = CODE_W'(1);

  logic [PRE_W-1:0] preCnt;

  assign atFull = (code == FULL_CODE);

  always_ff @(posedge clk) begin
    if (rst || cmd.clear) begin
      code   <= '0;
      preCnt <= '0;
    end else if (cmd.step && !atFull) begin
      if (preCnt == PRE_LAST) begin
        preCnt <= '0;
        code   <= code + CODE_ONE;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // R6
  step_size_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(code) |-> (code == $past(code) + CODE_ONE) || (code == '0));

  // R6
  step_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!cmd.step && !cmd.clear) |=> $stable(code));

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (atFull && !cmd.clear) |=> atFull);
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ssq_pkg::*;
#(
  parameter int HOLD_CYCLES = 250,
  parameter int CODE_W      = 10,
  parameter int STEP_DIV    = 327
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supplyOk,
  input  logic              enableHi,
  input  logic              overTemp,
  input  logic              coolDown,
  output logic [CODE_W-1:0] refCode,
  output logic              runEn,
  output logic              rampDone
);
  localparam logic [CODE_W-1:0] FULL_CODE = '1;

  logic      supGood;
  logic      enGood;
  logic      rampFull;
  seqState_e state;
  rampCmd_t  cmd;

  ssq_deglitch #(
    .HOLD_CYCLES(HOLD_CYCLES), .FILTER_RISE(1'b1), .FILTER_FALL(1'b1)
  ) u_supFilt (
    .clk(clk), .rst(rst), .rawIn(supplyOk), .cleanOut(supGood)
  );

  ssq_deglitch #(
    .HOLD_CYCLES(HOLD_CYCLES), .FILTER_RISE(1'b0), .FILTER_FALL(1'b1)
  ) u_enFilt (
    .clk(clk), .rst(rst), .rawIn(enableHi), .cleanOut(enGood)
  );

  ssq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .supGood(supGood), .enGood(enGood),
    .overTemp(overTemp), .coolDown(coolDown), .rampFull(rampFull),
    .state(state), .cmd(cmd)
  );

  ssq_ramp #(.CODE_W(CODE_W), .STEP_DIV(STEP_DIV)) u_ramp (
    .clk(clk), .rst(rst), .cmd(cmd), .code(refCode), .atFull(rampFull)
  );

  assign runEn    = (state != SEQ_OFF);
  assign rampDone = (state == SEQ_RUN);

  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (rst)
    rampDone |-> refCode == FULL_CODE);
endmodule

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
  localparam int HOLD = 6;
  localparam int CW   = 5;
  localparam int DIV  = 3;
  localparam int FULL = (1 << CW) - 1;
  localparam int DONE_T = FULL * DIV + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supplyOk = 1'b0, enableHi = 1'b0, overTemp = 1'b0, coolDown = 1'b0;
  logic [CW-1:0] refCode;
  logic runEn, rampDone;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  softstart_seq #(.HOLD_CYCLES(HOLD), .CODE_W(CW), .STEP_DIV(DIV)) u_dut (
    .clk(clk), .rst(rst), .supplyOk(supplyOk), .enableHi(enableHi),
    .overTemp(overTemp), .coolDown(coolDown),
    .refCode(refCode), .runEn(runEn), .rampDone(rampDone)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitRun(input int limit, output int n);
    n = 0;
    while (!runEn && n < limit) begin
      tick();
      n++;
    end
  endtask

  // called on the tick where runEn rose; follows ramp to completion
  task automatic checkRamp(input string req);
    int expCode;
    check({req, " R6 start code"}, refCode, 0);
    for (int t = 1; t <= DONE_T + 6; t++) begin
      tick();
      expCode = (t / DIV > FULL) ? FULL : t / DIV;
      check({req, " R6 code"}, refCode, expCode);
      check({req, " R7 done"}, rampDone, (t >= DONE_T) ? 1 : 0);
    end
  endtask

  task automatic t_reset();
    check("R1 runEn in reset", runEn, 0);
    check("R1 code in reset", refCode, 0);
    rst = 1'b0;
    tick();
    check("R1 runEn after reset", runEn, 0);
    check("R1 done after reset", rampDone, 0);
  endtask

  task automatic t_supplyStart();
    int n;
    enableHi = 1'b1;
    tick(20);
    check("R4 no start without supply", runEn, 0);
    supplyOk = 1'b1;
    tick(HOLD - 2);
    supplyOk = 1'b0;
    tick();
    check("R2 bounce blocks start", runEn, 0);
    supplyOk = 1'b1;
    waitRun(40, n);
    check("R2 start latency", n, HOLD + 1);
    checkRamp("R2");
  endtask

  task automatic t_supplyDrop();
    supplyOk = 1'b0;
    for (int i = 0; i < HOLD - 1; i++) begin
      tick();
      check("R3 short dropout ignored", runEn, 1);
    end
    supplyOk = 1'b1;
    tick(3);
    check("R3 still running", rampDone, 1);
    supplyOk = 1'b0;
    tick(HOLD);
    check("R3 run before filter done", runEn, 1);
    tick();
    check("R3 run drops", runEn, 0);
    check("R3 code cleared", refCode, 0);
  endtask

  task automatic t_enable();
    int n;
    enableHi = 1'b0;
    supplyOk = 1'b1;
    tick(20);
    check("R4 no start without enable", runEn, 0);
    enableHi = 1'b1;
    tick();
    check("R4 enable rise accepted", runEn, 0);
    tick();
    check("R4 run one edge later", runEn, 1);
    enableHi = 1'b0;
    for (int i = 0; i < HOLD - 1; i++) begin
      tick();
      check("R5 short enable low ignored", runEn, 1);
    end
    enableHi = 1'b1;
    tick(2);
    enableHi = 1'b0;
    tick(HOLD);
    check("R5 run before filter done", runEn, 1);
    tick();
    check("R5 run drops", runEn, 0);
    check("R5 code cleared", refCode, 0);
    enableHi = 1'b1;
    waitRun(10, n);
    check("R4 restart latency", n, 2);
    checkRamp("R4");
  endtask

  task automatic t_thermal();
    overTemp = 1'b1;
    tick();
    overTemp = 1'b0;
    check("R8 run drops", runEn, 0);
    check("R8 done drops", rampDone, 0);
    check("R8 code cleared", refCode, 0);
    tick(20);
    check("R9 trip latched", runEn, 0);
    overTemp = 1'b1;
    coolDown = 1'b1;
    tick();
    overTemp = 1'b0;
    coolDown = 1'b0;
    tick(10);
    check("R9 trip wins over cooldown", runEn, 0);
    coolDown = 1'b1;
    tick();
    coolDown = 1'b0;
    check("R9 off on release edge", runEn, 0);
    tick();
    check("R9 restart after release", runEn, 1);
    checkRamp("R9");
  endtask

  task automatic t_thermalCycle();
    int n;
    for (int k = 0; k < 3; k++) begin
      overTemp = 1'b1;
      tick();
      overTemp = 1'b0;
      check("R10 trip stops", runEn, 0);
      tick(5);
      coolDown = 1'b1;
      tick();
      coolDown = 1'b0;
      waitRun(10, n);
      check("R10 restart latency", n, 1);
      checkRamp("R10");
    end
  endtask

  task automatic t_sameCycle();
    int n;
    overTemp = 1'b1;
    tick();
    overTemp = 1'b0;
    coolDown = 1'b1;
    tick();
    coolDown = 1'b0;
    waitRun(10, n);
    check("R11 restart", n, 1);
    tick(DONE_T - 1);
    check("R11 code at full", refCode, FULL);
    check("R11 not yet done", rampDone, 0);
    overTemp = 1'b1;
    tick();
    overTemp = 1'b0;
    check("R11 done suppressed", rampDone, 0);
    check("R11 run drops", runEn, 0);
    check("R11 code cleared", refCode, 0);
    tick(5);
    check("R11 stays off", rampDone, 0);
  endtask

  initial begin
    tick(3);
    t_reset();
    t_supplyStart();
    t_supplyDrop();
    t_enable();
    t_thermal();
    t_thermalCycle();
    t_sameCycle();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule